// File: doc/BRIEF.md
# Single-Clock FIFO with Misuse Detection

This block is a first-in first-out buffer for one clock domain. It stores up to `DEPTH` words of `WIDTH` bits. A producer writes a word by raising `push_i` with the word on `din_i`. A consumer takes the oldest word by raising `pop_i`, and the word appears on the registered `dout_o` after the clock edge. Both strobes may be raised in the same cycle. When the buffer is full, a push paired with a pop is accepted, because the pop frees a slot in the same edge.

Four registered status outputs report the occupancy: full, empty, almost full and almost empty. The almost-full mark sits at three quarters of `DEPTH` and the almost-empty mark at one quarter. A registered `err_o` pulses for one cycle after either kind of misuse: a push into a full buffer with no pop beside it, or a pop from an empty buffer. A misused operation changes neither the stored contents that matter nor the occupancy.

Reset is synchronous and active high. It clears the pointers and the occupancy, clears `dout_o` and `err_o`, and puts the flags into their empty-state values.

Top module: `sfifo_err`

## Requirements
- R1: With `rst` high at a clock edge, the outputs after that edge are `empty_o`=1, `aempty_o`=1, `full_o`=0, `afull_o`=0, `err_o`=0 and `dout_o`=0.
- R2: Words leave through `dout_o` in the order they were accepted. `dout_o` updates at the edge where a legal pop is sampled, and holds its value in every other cycle.
- R3: `full_o` is 1 exactly when the occupancy is `DEPTH`, and `empty_o` is 1 exactly when the occupancy is 0. Both take their new value at the same edge that applies the push or pop changing the occupancy.
- R4: `afull_o` is 1 exactly when the occupancy is at least 3*`DEPTH`/4 (12 by default). It changes at the same edge as R3.
- R5: `aempty_o` is 1 exactly when the occupancy is at most `DEPTH`/4 (4 by default). It changes at the same edge as R3.
- R6: A push while full with no pop in the same cycle is dropped. The occupancy stays at `DEPTH`, and `err_o` is 1 in the following cycle.
- R7: A pop while empty leaves `dout_o` and the occupancy unchanged, and `err_o` is 1 in the following cycle.
- R8: A push together with a pop while empty raises `err_o` in the following cycle. The pushed word is still stored, so the occupancy becomes 1, and a later pop returns that word.
- R9: A push together with a pop while full raises no error. The buffer stays full, and `dout_o` receives the oldest word.
- R10: A push together with a pop at an occupancy between 1 and `DEPTH`-1 leaves the occupancy unchanged and raises no error.
- R11: `err_o` is not sticky. It is 0 in the cycle after any cycle that presented no misuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Write strobe |
| pop_i | input | 1 | Read strobe |
| din_i | input | WIDTH | Word to write |
| dout_o | output | WIDTH | Last word read (registered) |
| full_o | output | 1 | Occupancy equals DEPTH |
| empty_o | output | 1 | Occupancy is zero |
| afull_o | output | 1 | Occupancy at or above three quarters |
| aempty_o | output | 1 | Occupancy at or below one quarter |
| err_o | output | 1 | Misuse seen in the previous cycle |

## Verification
The bench targets the edges of occupancy.

- **Push and pop together while full (R9).** A design that checks only `full` before a push would reject the push and flag a false error.
- **Push and pop together while empty (R8).** A design that drops the whole operation would lose the pushed word. The next pop would then read stale data, or the buffer would stay empty.
- **Misuse must not change state (R6, R7).** The bench pushes into a full buffer and pops from an empty one. A design that moves a pointer on misuse would return words out of order later, or corrupt `dout_o`.
- **Threshold boundaries (R4, R5).** The bench steps occupancy across 4/5 and 11/12. An off-by-one comparison would show up at exactly those counts.
- **Error flag timing (R11).** A design with a sticky or late error flag would show a wrong `err_o` one cycle after the misuse.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_BOTH = 2'd3
    } op_e;

    typedef struct packed {
        logic full;
        logic empty;
        logic afull;
        logic aempty;
    } stat_t;

    function automatic int hi_mark(input int depth);
        return (depth * 3) / 4;
    endfunction

    function automatic int lo_mark(input int depth);
        return depth / 4;
    endfunction

    function automatic op_e decode_op(input logic push, input logic pop);
        return op_e'({pop, push});
    endfunction

endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    output logic          wr_en_o,
    output logic          rd_en_o,
    output logic [AW-1:0] wr_ptr_o,
    output logic [AW-1:0] rd_ptr_o,
    output logic [CW-1:0] cnt_nxt_o,
    output logic          err_o
);

    logic [CW-1:0] cnt_q;
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic          at_full, at_empty;
    logic          bad_push, bad_pop;
    logic          push_ok, pop_ok;
    op_e           op;

    assign at_full  = (cnt_q == CW'(DEPTH));
    assign at_empty = (cnt_q == '0);

    always_comb begin
        op       = decode_op(push_i, pop_i);
        bad_push = 1'b0;
        bad_pop  = 1'b0;
        push_ok  = 1'b0;
        pop_ok   = 1'b0;
        case (op)
            OP_PUSH: begin
                bad_push = at_full;
                push_ok  = !at_full;
            end
            OP_POP: begin
                bad_pop = at_empty;
                pop_ok  = !at_empty;
            end
            OP_BOTH: begin
                // a pop frees a slot, so the push is fine when full
                bad_pop = at_empty;
                pop_ok  = !at_empty;
                push_ok = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        cnt_nxt_o = cnt_q;
        if (push_ok && !pop_ok) cnt_nxt_o = cnt_q + 1'b1;
        else if (pop_ok && !push_ok) cnt_nxt_o = cnt_q - 1'b1;
        if (rst) cnt_nxt_o = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            err_o    <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt_o;
            err_o <= bad_push || bad_pop;
            if (push_ok)
                wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            if (pop_ok)
                rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
        end
    end

    assign wr_en_o  = push_ok && !rst;
    assign rd_en_o  = pop_ok && !rst;
    assign wr_ptr_o = wr_ptr_q;
    assign rd_ptr_o = rd_ptr_q;

    // R6: push on full without pop raises the error next cycle
    p_err_push_full_r6: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && cnt_q == CW'(DEPTH)) |=> err_o);

    // R7: pop on empty raises the error next cycle
    p_err_pop_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (pop_i && cnt_q == '0) |=> err_o);

    // R11: error drops after a clean cycle
    p_err_clears_r11: assert property (@(posedge clk) disable iff (rst)
        (!(push_i && !pop_i && cnt_q == CW'(DEPTH)) && !(pop_i && cnt_q == '0))
        |=> !err_o);

    // R10: a legal push+pop keeps the occupancy
    p_both_keeps_cnt_r10: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && cnt_q != '0) |=> $stable(cnt_q));

    // R3: occupancy never goes past capacity
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_ptr_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_en_i,
    input  logic [AW-1:0]    rd_ptr_i,
    output logic [WIDTH-1:0] rd_data_o
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) mem[wr_ptr_i] <= wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= mem[rd_ptr_i];
    end

    // R2: output word holds when nothing is read
    p_dout_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> $stable(rd_data_o));

endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int HI = hi_mark(DEPTH),
    localparam int LO = lo_mark(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt_nxt_i,
    output stat_t         stat_o
);

    stat_t stat_d;

    always_comb begin
        stat_d.full   = (cnt_nxt_i == CW'(DEPTH));
        stat_d.empty  = (cnt_nxt_i == '0);
        stat_d.afull  = (cnt_nxt_i >= CW'(HI));
        stat_d.aempty = (cnt_nxt_i <= CW'(LO));
    end

    always_ff @(posedge clk) begin
        if (rst) stat_o <= '{full: 1'b0, empty: 1'b1, afull: 1'b0, aempty: 1'b1};
        else     stat_o <= stat_d;
    end

    // R1: reset puts the flags in the empty state
    p_reset_flags_r1: assert property (@(posedge clk)
        rst |=> (stat_o.empty && stat_o.aempty && !stat_o.full && !stat_o.afull));

    // R3: full and empty are exclusive
    p_full_empty_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(stat_o.full && stat_o.empty));

    // R4: full implies almost full
    p_afull_covers_full_r4: assert property (@(posedge clk) disable iff (rst)
        stat_o.full |-> stat_o.afull);

    // R5: empty implies almost empty
    p_aempty_covers_empty_r5: assert property (@(posedge clk) disable iff (rst)
        stat_o.empty |-> stat_o.aempty);

endmodule

// File: rtl/sfifo_err.sv
module sfifo_err
    import sfifo_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             afull_o,
    output logic             aempty_o,
    output logic             err_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          wr_en, rd_en;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_nxt;
    stat_t         stat;

    sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .wr_en_o   (wr_en),
        .rd_en_o   (rd_en),
        .wr_ptr_o  (wr_ptr),
        .rd_ptr_o  (rd_ptr),
        .cnt_nxt_o (cnt_nxt),
        .err_o     (err_o)
    );

    sfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_ptr_i  (wr_ptr),
        .wr_data_i (din_i),
        .rd_en_i   (rd_en),
        .rd_ptr_i  (rd_ptr),
        .rd_data_o (dout_o)
    );

    sfifo_flags #(.DEPTH(DEPTH)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .cnt_nxt_i (cnt_nxt),
        .stat_o    (stat)
    );

    assign full_o   = stat.full;
    assign empty_o  = stat.empty;
    assign afull_o  = stat.afull;
    assign aempty_o = stat.aempty;

endmodule

// File: tb/sfifo_err_tb.sv
module sfifo_err_tb;

    localparam int WIDTH = 32;
    localparam int DEPTH = 16;
    localparam int HI = (DEPTH * 3) / 4;
    localparam int LO = DEPTH / 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             push_i = 1'b0;
    logic             pop_i = 1'b0;
    logic [WIDTH-1:0] din_i = '0;
    logic [WIDTH-1:0] dout_o;
    logic             full_o, empty_o, afull_o, aempty_o, err_o;

    int checks = 0;
    int errors = 0;

    logic [WIDTH-1:0] q[$];
    logic [WIDTH-1:0] exp_dout = '0;
    logic             exp_err = 1'b0;

    always #2 clk = ~clk;

    sfifo_err #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .din_i(din_i),
        .dout_o(dout_o), .full_o(full_o), .empty_o(empty_o), .afull_o(afull_o),
        .aempty_o(aempty_o), .err_o(err_o)
    );

    function automatic bit exp_afull(int n); return n >= HI; endfunction
    function automatic bit exp_aempty(int n); return n <= LO; endfunction

    task automatic chk(input string tg, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tg, $time, act, exp);
        end
    endtask

    task automatic check_flags(input string tfe);
        int n = q.size();
        chk({tfe, " full"}, full_o, n == DEPTH);
        chk({tfe, " empty"}, empty_o, n == 0);
        chk("R4 afull", afull_o, exp_afull(n));
        chk("R5 aempty", aempty_o, exp_aempty(n));
    endtask

    task automatic do_reset();
        rst = 1'b1; push_i = 1'b0; pop_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        q.delete(); exp_dout = '0; exp_err = 1'b0;
        chk("R1 empty", empty_o, 1'b1);
        chk("R1 aempty", aempty_o, 1'b1);
        chk("R1 full", full_o, 1'b0);
        chk("R1 afull", afull_o, 1'b0);
        chk("R1 err", err_o, 1'b0);
        chk("R1 dout", dout_o, '0);
        rst = 1'b0;
    endtask

    task automatic step(input bit pu, input bit po, input logic [WIDTH-1:0] d);
        int n;
        bit perr, oerr, pop_ok, push_ok;
        string terr, tdo, tfe;
        push_i = pu; pop_i = po; din_i = d;
        @(posedge clk);
        n = q.size();
        perr = pu && !po && n == DEPTH;
        oerr = po && n == 0;
        pop_ok = po && n != 0;
        push_ok = pu && (n != DEPTH || pop_ok);
        terr = perr ? "R6" : (oerr ? (pu ? "R8" : "R7") : "R11");
        tdo = (pop_ok && pu && n == DEPTH) ? "R9" : (oerr ? "R7" : "R2");
        tfe = (pu && po && n != 0) ? "R10" : "R3";
        exp_err = perr || oerr;
        if (pop_ok) exp_dout = q.pop_front();
        if (push_ok) q.push_back(d);
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0;
        chk({terr, " err"}, err_o, exp_err);
        chk({tdo, " dout"}, dout_o, exp_dout);
        check_flags(tfe);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [WIDTH-1:0] w;
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        do_reset();

        // R7: pop on empty
        step(1'b0, 1'b1, '0);
        // R11: error clears
        step(1'b0, 1'b0, '0);
        // R8: push+pop on empty, word is kept
        step(1'b1, 1'b1, 32'hCAFE_0001);
        chk("R8 not empty", empty_o, 1'b0);
        step(1'b0, 1'b1, '0);
        chk("R8 word kept", dout_o, 32'hCAFE_0001);

        // fill across the thresholds (R3, R4, R5)
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 32'h1000 + i);
        chk("R3 full reached", full_o, 1'b1);
        // R6: push on full dropped
        step(1'b1, 1'b0, 32'hDEAD_BEEF);
        step(1'b1, 1'b0, 32'hDEAD_BEF0);
        // R9: push+pop on full
        step(1'b1, 1'b1, 32'h2000);
        chk("R9 oldest out", dout_o, 32'h1000);
        chk("R9 still full", full_o, 1'b1);
        // drain, dropped words must not appear (R6, R2)
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, '0);
        chk("R6 last word", dout_o, 32'h2000);
        step(1'b0, 1'b1, '0);

        // reset while holding data
        for (int i = 0; i < 13; i++) step(1'b1, 1'b0, $urandom());
        do_reset();

        // random phases with different bias
        for (int ph = 0; ph < 3; ph++) begin
            int pp = (ph == 0) ? 70 : (ph == 1) ? 30 : 50;
            for (int i = 0; i < 1500; i++) begin
                bit pu = ($urandom_range(99) < pp);
                bit po = ($urandom_range(99) < (100 - pp));
                w = $urandom();
                step(pu, po, w);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule